// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block holds the inter-processor interrupt state of a small multi-core interrupt controller. Every CPU owns two message sources, called "other" and "self", each with its own pending bit and mask bit. A CPU raises "other" messages on any group of CPUs by writing a destination bitmap to a send register. It acknowledges and masks its own sources through a local register view, or reaches any CPU's sources through a per-CPU window.

A CPU learns what to service by reading its event register. A pending hardware interrupt (signalled from outside this block) is reported before any message. When a message is reported, that message is masked in the same step. It stays masked until software writes the mask-clear register. The pending bit is not touched by the read, so software still has to acknowledge it.

Top module: `ipi_unit`

## Requirements
- R1: A write to address 0x2008 sets the "other" pending bit of every CPU c whose data bit c is set. Data bits at or above the CPU count are ignored.
- R2: A write to address 0x200C clears pending bits of the requesting CPU. Data bit 0 selects "other" and data bit 31 selects "self".
- R3: Writes to 0x2024 set mask bits and writes to 0x2028 clear mask bits of the requesting CPU. Data bit 0 selects "other" and data bit 31 selects "self".
- R4: Addresses 0x5000 + c*128 + offset act on CPU c whatever the requester is. Offset 0x08 sets pending, 0x0C clears pending, 0x24 sets mask and 0x28 clears mask, with the same bit selects as R2. A window index at or above the CPU count has no effect.
- R5: A one-cycle read strobe loads the requester's event word into evt_data on the next clock, where it is held until the next read. The word has type in bits 31:16 and number in bits 15:0. Type 4 with number 1 is "other", type 4 with number 2 is "self", and 0 means nothing is deliverable.
- R6: Reporting a message masks that message for the reading CPU. Its pending bit stays set, so clearing the mask alone delivers it again.
- R7: A pending message that is masked is kept. It becomes deliverable once it is unmasked.
- R8: Within one CPU, the order of precedence is hardware interrupt first (type 1, number taken from hw_num), then "other", then "self". Reporting a hardware interrupt masks no message.
- R9: After reset, all pending bits are 0, all mask bits are 1, evt_data is 0 and irq_out is 0.
- R10: Repeated sends to a CPU whose "other" message is already pending leave a single pending message. One acknowledge clears it.
- R11: irq_out[c] is 1 exactly when CPU c has a hardware interrupt or an unmasked pending message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cpu | input | CW | Index of the CPU issuing the access |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_evt | input | 1 | Event register read strobe for req_cpu |
| hw_pend | input | NCPU | Per-CPU hardware interrupt pending |
| hw_num | input | NCPU*16 | Per-CPU hardware interrupt number, CPU c in bits 16c+15:16c |
| evt_data | output | 32 | Last event word read |
| irq_out | output | NCPU | Per-CPU interrupt request |

## Verification
Every one of the sixteen destination bitmaps is sent from each of the four requesters. Each time, every CPU's event word and request line is compared with the bitmap. This shows which destination bits are honoured and confirms that the issuing CPU has no influence on where a send lands. Odd-numbered passes send the same bitmap twice, which separates a single pending bit from a counted one. A stacked case puts a hardware interrupt together with both messages on one CPU. It exposes the precedence order, shows that each claim masks the right source, and shows that clearing a mask redelivers a message that was never acknowledged. Out-of-range window indices and masked sends check that stimulus meant to have no effect leaves every CPU untouched.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam logic [15:0] A_SEND   = 16'h2008;
    localparam logic [15:0] A_ACK    = 16'h200C;
    localparam logic [15:0] A_MSET   = 16'h2024;
    localparam logic [15:0] A_MCLR   = 16'h2028;
    localparam logic [3:0]  WIN_PAGE = 4'h5;
    localparam logic [6:0]  W_SET    = 7'h08;
    localparam logic [6:0]  W_CLR    = 7'h0C;
    localparam logic [6:0]  W_MSET   = 7'h24;
    localparam logic [6:0]  W_MCLR   = 7'h28;
    localparam logic [15:0] EVT_HW    = 16'd1;
    localparam logic [15:0] EVT_IPI   = 16'd4;
    localparam logic [15:0] NUM_OTHER = 16'd1;
    localparam logic [15:0] NUM_SELF  = 16'd2;

    typedef struct packed {
        logic set_o;
        logic set_s;
        logic clr_o;
        logic clr_s;
        logic mset_o;
        logic mset_s;
        logic mclr_o;
        logic mclr_s;
    } ipi_op_t;

    typedef struct packed {
        logic pend_o;
        logic pend_s;
        logic mask_o;
        logic mask_s;
    } ipi_state_t;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int CW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                 wr_en,
    input  logic [CW-1:0]        req_cpu,
    input  logic [15:0]          wr_addr,
    input  logic [31:0]          wr_data,
    output ipi_op_t [NCPU-1:0]   ops
);
    logic       win_hit;
    logic [4:0] win_cpu;
    logic       is_me;
    logic       unused_data;

    assign unused_data = ^wr_data[30:1];

    always_comb begin
        ops     = '0;
        win_hit = wr_en && (wr_addr[15:12] == WIN_PAGE);
        win_cpu = wr_addr[11:7];
        is_me   = 1'b0;
        for (int c = 0; c < NCPU; c++) begin
            if (wr_en && wr_addr == A_SEND) begin
                ops[c].set_o = wr_data[c];
            end
            is_me = wr_en && (req_cpu == CW'(c));
            if (is_me) begin
                case (wr_addr)
                    A_ACK: begin
                        ops[c].clr_o = wr_data[0];
                        ops[c].clr_s = wr_data[31];
                    end
                    A_MSET: begin
                        ops[c].mset_o = wr_data[0];
                        ops[c].mset_s = wr_data[31];
                    end
                    A_MCLR: begin
                        ops[c].mclr_o = wr_data[0];
                        ops[c].mclr_s = wr_data[31];
                    end
                    default: ;
                endcase
            end
            if (win_hit && win_cpu == 5'(c)) begin
                case (wr_addr[6:0])
                    W_SET: begin
                        ops[c].set_o = wr_data[0];
                        ops[c].set_s = wr_data[31];
                    end
                    W_CLR: begin
                        ops[c].clr_o = wr_data[0];
                        ops[c].clr_s = wr_data[31];
                    end
                    W_MSET: begin
                        ops[c].mset_o = wr_data[0];
                        ops[c].mset_s = wr_data[31];
                    end
                    W_MCLR: begin
                        ops[c].mclr_o = wr_data[0];
                        ops[c].mclr_s = wr_data[31];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ipi_cpu_slice.sv
module ipi_cpu_slice
    import ipi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ipi_op_t     op,
    input  logic        claim,
    input  logic        hw_pend,
    input  logic [15:0] hw_num,
    output logic [31:0] evt,
    output logic        irq,
    output ipi_state_t  st
);
    ipi_state_t st_d, st_q;
    logic deliv_o, deliv_s, take_o, take_s;

    always_comb begin
        deliv_o = st_q.pend_o & ~st_q.mask_o;
        deliv_s = st_q.pend_s & ~st_q.mask_s;
        take_o  = ~hw_pend & deliv_o;
        take_s  = ~hw_pend & ~deliv_o & deliv_s;

        if (hw_pend)      evt = {EVT_HW, hw_num};
        else if (deliv_o) evt = {EVT_IPI, NUM_OTHER};
        else if (deliv_s) evt = {EVT_IPI, NUM_SELF};
        else              evt = '0;
        irq = hw_pend | deliv_o | deliv_s;

        st_d        = st_q;
        st_d.pend_o = (st_q.pend_o | op.set_o) & ~op.clr_o;
        st_d.pend_s = (st_q.pend_s | op.set_s) & ~op.clr_s;
        st_d.mask_o = ((st_q.mask_o | op.mset_o) & ~op.mclr_o) | (claim & take_o);
        st_d.mask_s = ((st_q.mask_s | op.mset_s) & ~op.mclr_s) | (claim & take_s);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pend_o: 1'b0, pend_s: 1'b0, mask_o: 1'b1, mask_s: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int CW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        req_cpu,
    input  logic                 wr_en,
    input  logic [15:0]          wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 rd_evt,
    input  logic [NCPU-1:0]      hw_pend,
    input  logic [NCPU*16-1:0]   hw_num,
    output logic [31:0]          evt_data,
    output logic [NCPU-1:0]      irq_out
);
    ipi_op_t    [NCPU-1:0]       ops;
    ipi_state_t [NCPU-1:0]       st;
    logic       [NCPU-1:0][31:0] slice_evt;
    logic       [NCPU-1:0]       claim;
    logic       [NCPU-1:0]       pend_o_v, pend_s_v, mask_o_v, mask_s_v;
    logic       [31:0]           evt_d, evt_q;

    ipi_decode #(.NCPU(NCPU), .CW(CW)) dec_i (
        .wr_en   (wr_en),
        .req_cpu (req_cpu),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ops     (ops)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign claim[c] = rd_evt && (req_cpu == CW'(c));
        ipi_cpu_slice slice_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (ops[c]),
            .claim   (claim[c]),
            .hw_pend (hw_pend[c]),
            .hw_num  (hw_num[c*16 +: 16]),
            .evt     (slice_evt[c]),
            .irq     (irq_out[c]),
            .st      (st[c])
        );
        assign pend_o_v[c] = st[c].pend_o;
        assign pend_s_v[c] = st[c].pend_s;
        assign mask_o_v[c] = st[c].mask_o;
        assign mask_s_v[c] = st[c].mask_s;
    end

    always_comb begin
        evt_d = evt_q;
        if (rd_evt) evt_d = slice_evt[req_cpu];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign evt_data = evt_q;
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
    import ipi_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int CW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CW-1:0]      req_cpu,
    input logic               wr_en,
    input logic [15:0]        wr_addr,
    input logic [31:0]        wr_data,
    input logic               rd_evt,
    input logic [NCPU-1:0]    hw_pend,
    input logic [31:0]        evt_data,
    input logic [NCPU-1:0]    pend_o_v,
    input logic [NCPU-1:0]    pend_s_v,
    input logic [NCPU-1:0]    mask_o_v,
    input logic [NCPU-1:0]    mask_s_v
);
    p_reset_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_o_v == '0 && pend_s_v == '0 &&
                          mask_o_v == '1 && mask_s_v == '1 && evt_data == '0));

    p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ACK && wr_data[0]) |=> !pend_o_v[$past(req_cpu)]);

    p_claim_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> (evt_data != {EVT_IPI, NUM_OTHER}) || mask_o_v[$past(req_cpu)]);

    p_hw_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && hw_pend[req_cpu]) |=> (evt_data[31:16] == EVT_HW));

    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        p_send_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_SEND && wr_data[c]) |=> pend_o_v[c]);

        p_pending_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o_v[c] && !wr_en) |=> pend_o_v[c]);

        p_self_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_s_v[c] && !wr_en) |=> pend_s_v[c]);
    end
endmodule

bind ipi_unit ipi_unit_chk #(.NCPU(NCPU), .CW(CW)) chk_i (.*);

// File: tb/ipi_unit_tb_top.sv
module ipi_unit_tb_top;
    localparam int NCPU = 4;
    localparam int CW   = 2;
    localparam logic [15:0] A_SEND = 16'h2008;
    localparam logic [15:0] A_ACK  = 16'h200C;
    localparam logic [15:0] A_MSET = 16'h2024;
    localparam logic [15:0] A_MCLR = 16'h2028;
    localparam logic [31:0] EV_OTHER = 32'h0004_0001;
    localparam logic [31:0] EV_SELF  = 32'h0004_0002;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [CW-1:0]       req_cpu = '0;
    logic                wr_en = 1'b0;
    logic [15:0]         wr_addr = '0;
    logic [31:0]         wr_data = '0;
    logic                rd_evt = 1'b0;
    logic [NCPU-1:0]     hw_pend = '0;
    logic [NCPU*16-1:0]  hw_num = '0;
    logic [31:0]         evt_data;
    logic [NCPU-1:0]     irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] e;

    always #2 clk = ~clk;

    ipi_unit #(.NCPU(NCPU), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_cpu(req_cpu), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_evt(rd_evt),
        .hw_pend(hw_pend), .hw_num(hw_num), .evt_data(evt_data), .irq_out(irq_out)
    );

    function automatic logic [15:0] win(input int cpu, input logic [6:0] off);
        return 16'h5000 + 16'(cpu * 128) + {9'd0, off};
    endfunction

    task automatic wr(input int cpu, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_cpu = CW'(cpu); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int cpu, output logic [31:0] v);
        @(negedge clk);
        req_cpu = CW'(cpu); rd_evt = 1'b1;
        @(negedge clk);
        rd_evt = 1'b0;
        v = evt_data;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 irq after reset", 32'(irq_out), 32'd0);
        chk("R9 evt after reset", evt_data, 32'd0);

        // R9: masks set at reset, so a raised message stays hidden
        wr(0, win(1, 7'h08), 32'h1);
        chk("R9 masked irq", 32'(irq_out), 32'd0);
        rd(1, e);
        chk("R9 masked event", e, 32'd0);
        // R7: unmask delivers the kept message
        wr(2, win(1, 7'h28), 32'h1);
        chk("R7 unmask delivers", 32'(irq_out), 32'h2);
        rd(1, e);
        chk("R5 other event", e, EV_OTHER);
        chk("R6 claim masks", 32'(irq_out), 32'd0);
        wr(1, A_ACK, 32'h1);
        wr(1, A_MCLR, 32'h1);
        chk("R2 ack cleared", 32'(irq_out), 32'd0);

        // unmask everything through windows (R4)
        for (int c = 0; c < NCPU; c++) wr(0, win(c, 7'h28), 32'h8000_0001);
        chk("R4 unmask no pend", 32'(irq_out), 32'd0);

        // R1/R10 sweep over all bitmaps and requesters
        for (int b = 0; b < 16; b++) begin
            for (int s = 0; s < NCPU; s++) begin
                wr(s, A_SEND, 32'h5A5A_5A50 | 32'(b));
                if (s % 2 == 1) wr(s, A_SEND, 32'h0000_0FF0 | 32'(b));
                chk("R1 R11 send irq", 32'(irq_out), 32'(b));
                for (int c = 0; c < NCPU; c++) begin
                    rd(c, e);
                    chk("R5 sweep event", e, b[c] ? EV_OTHER : 32'd0);
                end
                chk("R6 sweep masked", 32'(irq_out), 32'd0);
                for (int c = 0; c < NCPU; c++) begin
                    wr(c, A_ACK, 32'h1);
                    wr(c, A_MCLR, 32'h1);
                end
                chk("R10 R2 single ack", 32'(irq_out), 32'd0);
            end
        end

        // R3: local mask set/clear
        wr(3, A_MSET, 32'h1);
        wr(0, A_SEND, 32'h8);
        chk("R3 local mask hides", 32'(irq_out), 32'd0);
        wr(3, A_MCLR, 32'h1);
        chk("R3 local unmask", 32'(irq_out), 32'h8);
        wr(3, A_ACK, 32'h1);
        chk("R2 local ack", 32'(irq_out), 32'd0);

        // R4: out-of-range window index has no effect
        wr(0, win(5, 7'h08), 32'h8000_0001);
        wr(0, win(6, 7'h24), 32'h8000_0001);
        wr(0, A_SEND, 32'h1);
        chk("R4 bad window", 32'(irq_out), 32'h1);
        rd(0, e);
        chk("R4 bad window mask", e, EV_OTHER);
        wr(0, A_ACK, 32'h1);
        wr(0, A_MCLR, 32'h1);

        // R8: precedence on CPU 2
        wr(0, win(2, 7'h08), 32'h8000_0001);
        hw_num[2*16 +: 16] = 16'h0ABC;
        hw_pend[2] = 1'b1;
        rd(2, e);
        chk("R8 hw first", e, 32'h0001_0ABC);
        hw_pend[2] = 1'b0;
        rd(2, e);
        chk("R8 other second", e, EV_OTHER);
        rd(2, e);
        chk("R8 self third", e, EV_SELF);
        rd(2, e);
        chk("R6 all claimed", e, 32'd0);
        chk("R6 irq low", 32'(irq_out), 32'd0);
        wr(3, win(2, 7'h28), 32'h1);
        rd(2, e);
        chk("R6 redeliver unacked", e, EV_OTHER);
        wr(1, win(2, 7'h0C), 32'h8000_0001);
        wr(1, win(2, 7'h28), 32'h8000_0001);
        chk("R4 window clear", 32'(irq_out), 32'd0);

        // R11/R8: hardware line alone, claim masks no message
        hw_num[1*16 +: 16] = 16'h0033;
        hw_pend[1] = 1'b1;
        @(negedge clk);
        chk("R11 hw irq", 32'(irq_out), 32'h2);
        rd(1, e);
        chk("R8 hw event", e, 32'h0001_0033);
        hw_pend[1] = 1'b0;
        wr(0, A_SEND, 32'h2);
        chk("R8 hw claim kept mask open", 32'(irq_out), 32'h2);
        rd(1, e);
        chk("R5 held word", evt_data, EV_OTHER);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule